// File: doc/BRIEF.md
# Two-Level Interrupt Mask Controller

This block gates level-sensitive device interrupts for a small multi-core cluster. Each source passes two gates before it reaches a core. One is a shared enable bit per source. The other is a per-core mask bit, and for shared sources also a routing field that names which cores may take the source. Each core has one interrupt line. That line is high whenever at least one source can be delivered to that core.

Software reaches the block through a single register port. A window select picks either the shared register window or the per-core window. A core tag on the access names the issuing core, and per-core registers act on that core only. Enable and mask bits are never rewritten as whole vectors. Software writes a source number to a dedicated set or clear register instead. A per-core acknowledge register returns the lowest-numbered source that is deliverable to the reading core. When nothing is deliverable it returns 1023. Source numbers 0 and 1 are reserved summary slots. They never reach a core. Sources 2 to 28 behave as per-core interrupts, and every higher number is a shared interrupt.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset every shared enable is clear, every per-core mask bit is set, every routing field reads 0, every core interrupt output is low, and every core's acknowledge register reads 1023.
- R2: A shared-window write of value N to offset 0x30 sets the enable of source N, and a write of N to offset 0x34 clears it. Either write takes effect from the next clock edge. A value N that is not below the number of sources changes nothing.
- R3: A per-core-window write of N to offset 0x48 sets the mask bit of source N for the tagged core only, and a write of N to offset 0x4C clears that bit. A value N that is not below the number of sources changes nothing.
- R4: The routing register of source N sits at shared offset 0x100 + 4*N. Bit c (bits 3:0) and bit 8+c (bits 11:8) each route the source to core c, and either one is enough. Only the bits for implemented cores are stored and read back, and all other bits read as 0.
- R5: A source numbered 2 to 28 is deliverable to core c when its input is high, its enable is set and core c's mask bit for it is clear. Its routing field plays no part.
- R6: A source numbered 29 or above is deliverable to core c only when its input is high, its enable is set, core c's mask bit for it is clear and it is routed to core c.
- R7: Sources 0 and 1 are never deliverable, whatever their input, enable, mask and routing.
- R8: Reading shared offset 0x00 returns the number of implemented sources in bits 12:2, with every other bit 0.
- R9: Reading per-core offset 0x44 returns, in bits 9:0, the lowest-numbered source deliverable to the tagged core, or 1023 when none is deliverable. All higher bits are 0, and the read changes no state.
- R10: Each core's interrupt output is high in exactly the cycles in which that core's acknowledge value is not 1023. It follows inputs and register state without added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_percore | input | 1 | 1 = per-core window, 0 = shared window |
| acc_core | input | CW (1) | Issuing core of the access |
| acc_addr | input | 12 | Byte offset within the selected window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current address, combinational |
| src_level | input | NUM_SRC (64) | Level interrupt inputs, one per source number |
| core_irq | output | NUM_CORES (2) | Interrupt request to each core |

## Verification
A wrong enable, mask or routing bit shows up as a core interrupt line that is wrong in the very cycle after the write that corrupted it. It also shows up as an acknowledge read that returns the wrong source number. A fault that is hidden behind a lower-numbered pending source only becomes visible once that lower source is masked or its input falls. For that reason the stimulus peels sources off one by one and compares the acknowledge value after each step. The 28/29 boundary, the reserved numbers 0 and 1, and out-of-range numbers that would alias onto a real source if the data were truncated each get a directed case. A random phase then runs with the model compared on every clock.

// File: rtl/dgi_pkg.sv
package dgi_pkg;

  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE = '1;
  localparam int RESERVED_IDS = 2;

  localparam logic [11:0] OFF_INFO       = 12'h000;
  localparam logic [11:0] OFF_EN_SET     = 12'h030;
  localparam logic [11:0] OFF_EN_CLR     = 12'h034;
  localparam logic [11:0] OFF_ACK        = 12'h044;
  localparam logic [11:0] OFF_MASK_SET   = 12'h048;
  localparam logic [11:0] OFF_MASK_CLR   = 12'h04C;
  localparam logic [11:0] OFF_ROUTE_BASE = 12'h100;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_EN_SET,
    OP_EN_CLR,
    OP_ROUTE_WR,
    OP_MASK_SET,
    OP_MASK_CLR
  } op_e;

  // True when addr hits the routing register of an implemented source.
  function automatic logic in_route_window(input logic [11:0] addr, input int nsrc);
    logic [12:0] lim;
    lim = 13'(256 + 4 * nsrc);
    return (addr >= OFF_ROUTE_BASE) && ({1'b0, addr} < lim) && (addr[1:0] == 2'b00);
  endfunction

  function automatic logic [ID_W-1:0] route_index(input logic [11:0] addr);
    logic [11:0] rel;
    rel = addr - OFF_ROUTE_BASE;
    return ID_W'(rel >> 2);
  endfunction

endpackage

// File: rtl/dgi_source_bank.sv
module dgi_source_bank
  import dgi_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  op_e                                      op,
  input  logic [ID_W-1:0]                          src_id,
  input  logic [2*NUM_CORES-1:0]                   route_wr,
  output logic [NUM_SRC-1:0]                       enable_o,
  output logic [NUM_SRC-1:0][2*NUM_CORES-1:0]      route_o
);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit;
    assign hit = (src_id == ID_W'(n));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enable_o[n] <= 1'b0;
        route_o[n]  <= '0;
      end else if (hit) begin
        case (op)
          OP_EN_SET:   enable_o[n] <= 1'b1;
          OP_EN_CLR:   enable_o[n] <= 1'b0;
          OP_ROUTE_WR: route_o[n]  <= route_wr;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dgi_core_gate.sv
module dgi_core_gate
  import dgi_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int PERCORE_N = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_e                op,
  input  logic               core_sel,
  input  logic [ID_W-1:0]    src_id,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] route_col,
  output logic               irq_o,
  output logic [ID_W-1:0]    ack_id_o
);

  // Sources that may ever reach a core (reserved slots excluded).
  function automatic logic [NUM_SRC-1:0] ordinary_set();
    logic [NUM_SRC-1:0] v;
    for (int n = 0; n < NUM_SRC; n++) v[n] = (n >= RESERVED_IDS);
    return v;
  endfunction

  // Sources whose delivery also depends on the routing field.
  function automatic logic [NUM_SRC-1:0] routed_set();
    logic [NUM_SRC-1:0] v;
    for (int n = 0; n < NUM_SRC; n++) v[n] = (n >= PERCORE_N);
    return v;
  endfunction

  localparam logic [NUM_SRC-1:0] ORDINARY = ordinary_set();
  localparam logic [NUM_SRC-1:0] ROUTED   = routed_set();

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] deliver;
  logic               mask_set_ev;
  logic               mask_clr_ev;

  assign mask_set_ev = core_sel && (op == OP_MASK_SET);
  assign mask_clr_ev = core_sel && (op == OP_MASK_CLR);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)                                     mask_q[n] <= 1'b1;
      else if (mask_set_ev && src_id == ID_W'(n))     mask_q[n] <= 1'b1;
      else if (mask_clr_ev && src_id == ID_W'(n))     mask_q[n] <= 1'b0;
    end
  end

  assign deliver = src_level & enable_i & ~mask_q & ORDINARY & (~ROUTED | route_col);

  always_comb begin
    ack_id_o = ID_NONE;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (deliver[n]) ack_id_o = ID_W'(n);
    end
  end

  assign irq_o = |deliver;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !irq_o); // R1
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_set_ev |=> (ack_id_o != $past(src_id))); // R3
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_id_o != ID_W'(0)) && (ack_id_o != ID_W'(1))); // R7
  AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_id_o == ID_NONE) || (ack_id_o < ID_W'(NUM_SRC))); // R9
  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (ack_id_o != ID_NONE)); // R10

endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import dgi_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 2,
  parameter int PERCORE_N = 29,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_percore,
  input  logic [CW-1:0]        acc_core,
  input  logic [11:0]          acc_addr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          rd_data,
  input  logic [NUM_SRC-1:0]   src_level,
  output logic [NUM_CORES-1:0] core_irq
);

  logic                                    wr_en;
  logic                                    id_ok;
  logic                                    route_win;
  logic [ID_W-1:0]                         route_idx;
  logic [ID_W-1:0]                         src_id;
  op_e                                     op;
  logic [NUM_SRC-1:0]                      enable_q;
  logic [NUM_SRC-1:0][2*NUM_CORES-1:0]     route_q;
  logic [2*NUM_CORES-1:0]                  route_wr;
  logic [NUM_CORES-1:0][ID_W-1:0]          ack_all;
  logic [ID_W-1:0]                         rd_ack;

  assign wr_en     = acc_valid && acc_write;
  assign id_ok     = (acc_wdata < 32'(NUM_SRC));
  assign route_win = in_route_window(acc_addr, NUM_SRC);
  assign route_idx = route_index(acc_addr);
  assign route_wr  = {acc_wdata[8 +: NUM_CORES], acc_wdata[0 +: NUM_CORES]};

  always_comb begin
    op = OP_IDLE;
    if (wr_en && !acc_percore) begin
      if (acc_addr == OFF_EN_SET && id_ok)      op = OP_EN_SET;
      else if (acc_addr == OFF_EN_CLR && id_ok) op = OP_EN_CLR;
      else if (route_win)                       op = OP_ROUTE_WR;
    end else if (wr_en && acc_percore && id_ok) begin
      if (acc_addr == OFF_MASK_SET)      op = OP_MASK_SET;
      else if (acc_addr == OFF_MASK_CLR) op = OP_MASK_CLR;
    end
  end

  assign src_id = (op == OP_ROUTE_WR) ? route_idx : acc_wdata[ID_W-1:0];

  dgi_source_bank #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .src_id   (src_id),
    .route_wr (route_wr),
    .enable_o (enable_q),
    .route_o  (route_q)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_SRC-1:0] col;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
      assign col[n] = route_q[n][c] | route_q[n][NUM_CORES + c];
    end

    dgi_core_gate #(.NUM_SRC(NUM_SRC), .PERCORE_N(PERCORE_N)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .core_sel  (acc_core == CW'(c)),
      .src_id    (src_id),
      .src_level (src_level),
      .enable_i  (enable_q),
      .route_col (col),
      .irq_o     (core_irq[c]),
      .ack_id_o  (ack_all[c])
    );

    AST_SHARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_EN_CLR && src_id >= ID_W'(PERCORE_N)) |=> (ack_all[c] != $past(src_id))); // R2
  end

  always_comb begin
    rd_ack = ID_NONE;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (acc_core == CW'(c)) rd_ack = ack_all[c];
    end
  end

  always_comb begin
    rd_data = '0;
    if (!acc_percore) begin
      if (acc_addr == OFF_INFO) begin
        rd_data[12:2] = 11'(NUM_SRC);
      end else if (route_win) begin
        for (int n = 0; n < NUM_SRC; n++) begin
          if (route_idx == ID_W'(n)) begin
            rd_data[0 +: NUM_CORES] = route_q[n][NUM_CORES-1:0];
            rd_data[8 +: NUM_CORES] = route_q[n][2*NUM_CORES-1:NUM_CORES];
          end
        end
      end
    end else if (acc_addr == OFF_ACK) begin
      rd_data[ID_W-1:0] = rd_ack;
    end
  end

  AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_write || !acc_valid) |-> (op == OP_IDLE)); // R9

endmodule

// File: tb/tb_dual_gate_intc.sv
`timescale 1ns/1ps
module tb_dual_gate_intc;

  localparam int NS = 64;
  localparam int NC = 2;
  localparam int PC = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_percore = 1'b0;
  logic [0:0]  acc_core = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic [NS-1:0] lvl = '0;
  logic [NC-1:0] core_irq;

  int checks = 0;
  int errors = 0;
  bit monitor_on = 0;

  int m_en [NS];
  int m_mask [NC][NS];
  int m_route [NS];

  always #5 clk = ~clk;

  dual_gate_intc #(.NUM_SRC(NS), .NUM_CORES(NC), .PERCORE_N(PC)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_percore(acc_percore), .acc_core(acc_core), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .src_level(lvl), .core_irq(core_irq)
  );

  function automatic int model_ack(int c);
    for (int n = 2; n < NS; n++) begin
      bit routed;
      routed = (n < PC) || (((m_route[n] >> c) & 1) == 1) || (((m_route[n] >> (8 + c)) & 1) == 1);
      if (lvl[n] && m_en[n] == 1 && m_mask[c][n] == 0 && routed) return n;
    end
    return 1023;
  endfunction

  function automatic void model_reset();
    for (int n = 0; n < NS; n++) begin
      m_en[n] = 0;
      m_route[n] = 0;
      for (int c = 0; c < NC; c++) m_mask[c][n] = 1;
    end
  endfunction

  function automatic void model_write(bit pc, int core, int addr, int data);
    if (!pc) begin
      if (addr == 'h30 && data < NS && data >= 0) m_en[data] = 1;
      else if (addr == 'h34 && data < NS && data >= 0) m_en[data] = 0;
      else if (addr >= 'h100 && addr < 'h100 + 4 * NS && addr % 4 == 0)
        m_route[(addr - 'h100) / 4] = data & 'h303;
    end else if (data < NS && data >= 0) begin
      if (addr == 'h48) m_mask[core][data] = 1;
      else if (addr == 'h4C) m_mask[core][data] = 0;
    end
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", req, act, act, exp, exp, $time);
    end
  endtask

  task automatic wr(bit pc, int core, int addr, int data);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_percore = pc;
    acc_core = core[0]; acc_addr = addr[11:0]; acc_wdata = data;
    @(posedge clk);
    model_write(pc, core, addr, data);
    #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(bit pc, int core, int addr, int exp, string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_percore = pc;
    acc_core = core[0]; acc_addr = addr[11:0];
    #1;
    chk(rd_data == exp, req, int'(rd_data), exp);
    acc_valid = 0;
  endtask

  task automatic ack(int core, int exp, string req);
    rd(1, core, 'h44, exp, req);
  endtask

  task automatic set_lvl(logic [NS-1:0] v);
    @(negedge clk);
    lvl = v;
  endtask

  // Per-clock comparison of each core line against the model (R10)
  always @(posedge clk) begin
    #4;
    if (monitor_on) begin
      for (int c = 0; c < NC; c++) begin
        int e;
        e = (model_ack(c) != 1023) ? 1 : 0;
        chk(core_irq[c] == e[0], "R10 core_irq", int'(core_irq[c]), e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    monitor_on = 1;

    // R1 / R8 reset state
    rd(0, 0, 'h000, NS << 2, "R8 info");
    ack(0, 1023, "R1 ack core0");
    ack(1, 1023, "R1 ack core1");
    rd(0, 0, 'h1A0, 0, "R1 route40");

    set_lvl('1);
    wr(0, 0, 'h30, 5);
    ack(0, 1023, "R3 still masked");
    wr(1, 0, 'h4C, 5);
    ack(0, 5, "R5 src5 core0");
    ack(1, 1023, "R3 other core masked");

    // R6 shared source with routing
    wr(0, 0, 'h30, 40);
    wr(0, 0, 'h1A0, 'h002);
    ack(1, 1023, "R6 masked on core1");
    wr(1, 1, 'h4C, 40);
    ack(1, 40, "R6 src40 core1");
    wr(0, 0, 'h1A0, 'h102);
    wr(1, 0, 'h4C, 40);
    ack(0, 5, "R9 lowest wins");
    wr(1, 0, 'h48, 5);
    ack(0, 40, "R4 alt route bit");
    rd(0, 0, 'h1A0, 'h102, "R4 readback");
    wr(0, 0, 'h1A0, 'hFFFF_FFFF);
    rd(0, 0, 'h1A0, 'h303, "R4 stored bits");
    wr(0, 0, 'h1A0, 0);
    ack(1, 1023, "R6 unrouted");
    ack(0, 1023, "R6 unrouted core0");
    wr(0, 0, 'h1A0, 'h102);
    ack(1, 40, "R6 rerouted");

    // R2 global clear
    wr(0, 0, 'h34, 40);
    ack(0, 1023, "R2 cleared core0");
    ack(1, 1023, "R2 cleared core1");

    // R7 reserved sources
    for (int k = 0; k < 2; k++) begin
      wr(0, 0, 'h30, k);
      wr(1, 0, 'h4C, k);
      wr(0, 0, 'h100 + 4 * k, 'h303);
    end
    ack(0, 1023, "R7 reserved silent");
    wr(0, 0, 'h30, 2);
    wr(1, 0, 'h4C, 2);
    ack(0, 2, "R7 src2 is ordinary");
    wr(1, 0, 'h4C, 5);
    wr(1, 0, 'h48, 2);
    ack(0, 5, "R3 remask src2");

    // Out-of-range numbers that would alias to 5 if truncated
    wr(0, 0, 'h34, NS + 5);
    ack(0, 5, "R2 out of range clear");
    wr(1, 0, 'h48, NS + 5);
    ack(0, 5, "R3 out of range mask");

    // R5 per-core source ignores routing; 28/29 boundary
    wr(0, 0, 'h30, 10);
    wr(1, 1, 'h4C, 10);
    ack(1, 10, "R5 src10 unrouted");
    wr(0, 0, 'h30, 28);
    wr(0, 0, 'h30, 29);
    wr(1, 1, 'h4C, 28);
    wr(1, 1, 'h4C, 29);
    wr(1, 1, 'h48, 10);
    ack(1, 28, "R5 src28 unrouted");
    wr(1, 1, 'h48, 28);
    ack(1, 1023, "R6 src29 needs route");
    wr(0, 0, 'h100 + 4 * 29, 'h002);
    ack(1, 29, "R6 src29 routed");

    // Levels
    begin
      logic [NS-1:0] v;
      v = '1; v[29] = 1'b0; v[5] = 1'b0;
      set_lvl(v);
    end
    ack(1, 1023, "R6 input low");
    ack(0, 1023, "R5 input low");
    set_lvl('1);
    ack(0, 5, "R9 read once");
    ack(0, 5, "R9 read no side effect");

    // Random phase compared every clock
    for (int it = 0; it < 600; it++) begin
      int r, s, c;
      r = $urandom % 7;
      s = $urandom % (NS + 6);
      c = $urandom % NC;
      case (r)
        0: wr(0, c, 'h30, s);
        1: wr(0, c, 'h34, s);
        2: wr(1, c, 'h48, s);
        3: wr(1, c, 'h4C, s);
        4: wr(0, c, 'h100 + 4 * (s % NS), $urandom);
        5: begin
          logic [NS-1:0] v;
          v = lvl;
          v[s % NS] = ~v[s % NS];
          set_lvl(v);
        end
        default: rd(0, c, 'h100 + 4 * (s % NS), m_route[s % NS], "R4 random readback");
      endcase
      ack(c, model_ack(c), "R9 random ack");
    end

    monitor_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule